// File: doc/BRIEF.md
# System Control Port Register Block

This block is a byte-wide register file that sits on the I/O port bus of a small workstation-class board. It answers one lone port at 0x0092 and a window of ports from 0x0800 to 0x0851. Through these ports software can:

- request a soft reset and choose little-endian operation;
- drive the disk-activity lamp;
- keep a four-bit system control value;
- choose how CPU accesses to the I/O window are mapped onto port addresses.

Other ports return fixed identification and equipment bytes. Two ports send a one-cycle lock-toggle strobe to the nonvolatile memory. Any access to a port inside the decoded ranges that has no function in that direction raises a one-cycle error pulse.

Next to the register file sits a combinational translator. It turns a 23-bit CPU offset inside the I/O window into a 16-bit port address. In the flat map the low 16 offset bits pass straight through. In the sparse map, offset bits 4:0 are kept and offset bits 22:12 are packed just above them. The stored map-type bit chooses between the two maps. Register reads answer one clock after the request, with a valid strobe.

Top module: `sysport_top`

## Requirements
- R1: A write to port 0x0092 sets the soft_reset output from data bit 0 and the little_endian output from data bit 1. Both are levels that hold until the next write to 0x0092. A read of 0x0092 returns 0x00.
- R2: A write to port 0x0808 sets the disk_light output from data bit 0 and ignores the other data bits.
- R3: A write to port 0x081C stores data bits 3:0 on sys_ctl. A read of 0x081C returns the stored value with bits 7:4 zero.
- R4: A write to port 0x0850 stores data bit 0 as map_sparse. A read of 0x0850 returns that bit in bit 0, with bits 7:1 zero. No other access changes map_sparse.
- R5: A write to 0x0810 pulses nv_lock_a high for exactly the following cycle. A write to 0x0812 pulses nv_lock_b in the same way. The data value has no effect on either strobe.
- R6: Reads of the identification ports return fixed bytes: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39, 0x0818→0x00, 0x0823→0x03. A read of 0x0814 returns 0xFF. Writes to 0x0800, 0x0802, 0x0803 and 0x0814 change no output and raise no error.
- R7: A read of a decoded port that has no read function returns 0xFF and pulses acc_err for one cycle. A write to a decoded port that has no write function changes no state and pulses acc_err.
- R8: When map_sparse is 0, io_port equals cpu_offset bits 15:0.
- R9: When map_sparse is 1, io_port equals cpu_offset[4:0] in bits 4:0 and cpu_offset[22:12] in bits 15:5. This is the value (offset & 0x1F) | ((offset & 0x7FF000) >> 7).
- R10: A read request is answered by rd_valid and rd_data in the cycle after the request. A request outside port 0x0092 and the range 0x0800 to 0x0851 produces no rd_valid and no acc_err.
- R11: The synchronous reset rst clears every output register, including soft_reset, little_endian and map_sparse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_valid | input | 1 | Port access request this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| rd_data | output | 8 | Read data |
| acc_err | output | 1 | One-cycle pulse: access to an unassigned port |
| soft_reset | output | 1 | Software-requested reset level |
| little_endian | output | 1 | Little-endian mode level |
| disk_light | output | 1 | Disk activity lamp |
| sys_ctl | output | 4 | Stored system control value |
| map_sparse | output | 1 | I/O map type: 0 flat, 1 sparse |
| nv_lock_a | output | 1 | Lock-toggle strobe 1 to nonvolatile memory |
| nv_lock_b | output | 1 | Lock-toggle strobe 2 to nonvolatile memory |
| cpu_offset | input | 23 | CPU offset inside the I/O window |
| io_port | output | 16 | Translated port address |

## Verification
The bench checks the ports whose assignment depends on direction:

- 0x0808 and 0x0812 are write-only, so a read of either must return 0xFF and pulse acc_err.
- 0x0818 and 0x0823 are read-only, so a write to either must pulse acc_err.
- 0x0814 accepts both directions, so neither a read nor a write of it may raise acc_err.

A decoder that treated the window as symmetric would flag or miss one of these cases.

The bench also covers these points:

- Soft reset must clear when data bit 0 is written as 0 while little-endian mode stays set. A design that merged the two bits would fail here.
- Each lock strobe must fall after one cycle. A design that held it high would fail here.
- The translator is driven with an offset whose bits 11:5 are non-zero. A sparse map that did not drop those bits, or that shifted by the wrong amount, gives a wrong io_port.
- A hardware reset in the middle of the run must clear the map type back to flat.

// File: rtl/sysport_pkg.sv
package sysport_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int CTL_W   = 4;

    // decoded port addresses
    localparam logic [ADDR_W-1:0] A_SPECIAL = 16'h0092;
    localparam logic [ADDR_W-1:0] A_WIN_LO  = 16'h0800;
    localparam logic [ADDR_W-1:0] A_WIN_HI  = 16'h0851;
    localparam logic [ADDR_W-1:0] A_CPUCFG  = 16'h0800;
    localparam logic [ADDR_W-1:0] A_FEAT    = 16'h0802;
    localparam logic [ADDR_W-1:0] A_STAT    = 16'h0803;
    localparam logic [ADDR_W-1:0] A_LIGHT   = 16'h0808;
    localparam logic [ADDR_W-1:0] A_EQUIP   = 16'h080C;
    localparam logic [ADDR_W-1:0] A_LOCK1   = 16'h0810;
    localparam logic [ADDR_W-1:0] A_LOCK2   = 16'h0812;
    localparam logic [ADDR_W-1:0] A_CACHEIV = 16'h0814;
    localparam logic [ADDR_W-1:0] A_KEY     = 16'h0818;
    localparam logic [ADDR_W-1:0] A_SYSCTL  = 16'h081C;
    localparam logic [ADDR_W-1:0] A_CACHEST = 16'h0823;
    localparam logic [ADDR_W-1:0] A_MAPTYPE = 16'h0850;

    // fixed read bytes
    localparam logic [BYTE_W-1:0] V_CPUCFG  = 8'hEF;
    localparam logic [BYTE_W-1:0] V_FEAT    = 8'hAD;
    localparam logic [BYTE_W-1:0] V_STAT    = 8'hE0;
    localparam logic [BYTE_W-1:0] V_EQUIP   = 8'h3C;
    localparam logic [BYTE_W-1:0] V_XFEAT   = 8'h39;
    localparam logic [BYTE_W-1:0] V_KEY     = 8'h00;
    localparam logic [BYTE_W-1:0] V_CACHEST = 8'h03;
    localparam logic [BYTE_W-1:0] V_UNUSED  = 8'hFF;

    typedef enum logic [3:0] {
        P_NONE, P_SPECIAL, P_CPUCFG, P_FEAT, P_STAT, P_LIGHT, P_EQUIP,
        P_LOCK1, P_LOCK2, P_CACHEIV, P_KEY, P_SYSCTL, P_CACHEST, P_MAPTYPE
    } port_e;

    typedef struct packed {
        logic              soft_rst;
        logic              le;
        logic              light;
        logic [CTL_W-1:0]  sysctl;
        logic              sparse;
        logic              rd_valid;
        logic [BYTE_W-1:0] rd_data;
        logic              err;
        logic              lock_a;
        logic              lock_b;
    } regs_t;

endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
    import sysport_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              hit,
    output port_e             port,
    output logic              dir_ok
);

    always_comb begin
        hit = (addr == A_SPECIAL) || (addr >= A_WIN_LO && addr <= A_WIN_HI);
        unique case (addr)
            A_SPECIAL: port = P_SPECIAL;
            A_CPUCFG:  port = P_CPUCFG;
            A_FEAT:    port = P_FEAT;
            A_STAT:    port = P_STAT;
            A_LIGHT:   port = P_LIGHT;
            A_EQUIP:   port = P_EQUIP;
            A_LOCK1:   port = P_LOCK1;
            A_LOCK2:   port = P_LOCK2;
            A_CACHEIV: port = P_CACHEIV;
            A_KEY:     port = P_KEY;
            A_SYSCTL:  port = P_SYSCTL;
            A_CACHEST: port = P_CACHEST;
            A_MAPTYPE: port = P_MAPTYPE;
            default:   port = P_NONE;
        endcase
        // direction-dependent assignment
        if (is_write) begin
            dir_ok = port inside {P_SPECIAL, P_CPUCFG, P_FEAT, P_STAT, P_LIGHT,
                                  P_LOCK1, P_LOCK2, P_CACHEIV, P_SYSCTL, P_MAPTYPE};
        end else begin
            dir_ok = port inside {P_SPECIAL, P_CPUCFG, P_FEAT, P_STAT, P_EQUIP,
                                  P_LOCK1, P_CACHEIV, P_KEY, P_SYSCTL, P_CACHEST,
                                  P_MAPTYPE};
        end
    end

endmodule

// File: rtl/sysport_xlate.sv
module sysport_xlate #(
    parameter int OFFS_W = 23,
    parameter int PORT_W = 16
) (
    input  logic              sparse,
    input  logic [OFFS_W-1:0] offset,
    output logic [PORT_W-1:0] port_addr
);

    localparam int LOW_W  = 5;
    localparam int PAGE_B = 12;
    localparam int HI_W   = OFFS_W - PAGE_B;

    logic [PORT_W-1:0] flat_addr;
    logic [PORT_W-1:0] sparse_addr;

    generate
        if (HI_W + LOW_W == PORT_W) begin : g_exact
            assign sparse_addr = {offset[OFFS_W-1:PAGE_B], offset[LOW_W-1:0]};
        end else begin : g_resize
            assign sparse_addr = PORT_W'({offset[OFFS_W-1:PAGE_B], offset[LOW_W-1:0]});
        end
    endgenerate

    assign flat_addr = offset[PORT_W-1:0];

    always_comb begin
        port_addr = sparse ? sparse_addr : flat_addr;
    end

endmodule

// File: rtl/sysport_top.sv
module sysport_top
    import sysport_pkg::*;
#(
    parameter int OFFS_W = 23,
    parameter int PORT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_valid,
    input  logic                io_write,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [BYTE_W-1:0]   io_wdata,
    output logic                rd_valid,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                acc_err,
    output logic                soft_reset,
    output logic                little_endian,
    output logic                disk_light,
    output logic [CTL_W-1:0]    sys_ctl,
    output logic                map_sparse,
    output logic                nv_lock_a,
    output logic                nv_lock_b,
    input  logic [OFFS_W-1:0]   cpu_offset,
    output logic [PORT_W-1:0]   io_port
);

    regs_t  r_q, r_d;
    logic   dec_hit;
    port_e  dec_port;
    logic   dec_ok;

    sysport_decode u_dec (
        .addr     (io_addr),
        .is_write (io_write),
        .hit      (dec_hit),
        .port     (dec_port),
        .dir_ok   (dec_ok)
    );

    sysport_xlate #(.OFFS_W(OFFS_W), .PORT_W(PORT_W)) u_xlate (
        .sparse    (r_q.sparse),
        .offset    (cpu_offset),
        .port_addr (io_port)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        r_d.rd_data  = '0;
        r_d.err      = 1'b0;
        r_d.lock_a   = 1'b0;
        r_d.lock_b   = 1'b0;
        if (io_valid && dec_hit) begin
            if (io_write) begin
                r_d.err = !dec_ok;
                unique case (dec_port)
                    P_SPECIAL: begin
                        r_d.soft_rst = io_wdata[0];
                        r_d.le       = io_wdata[1];
                    end
                    P_LIGHT:   r_d.light  = io_wdata[0];
                    P_LOCK1:   r_d.lock_a = 1'b1;
                    P_LOCK2:   r_d.lock_b = 1'b1;
                    P_SYSCTL:  r_d.sysctl = io_wdata[CTL_W-1:0];
                    P_MAPTYPE: r_d.sparse = io_wdata[0];
                    default: ;
                endcase
            end else begin
                r_d.rd_valid = 1'b1;
                r_d.err      = !dec_ok;
                unique case (dec_port)
                    P_SPECIAL: r_d.rd_data = '0;
                    P_CPUCFG:  r_d.rd_data = V_CPUCFG;
                    P_FEAT:    r_d.rd_data = V_FEAT;
                    P_STAT:    r_d.rd_data = V_STAT;
                    P_EQUIP:   r_d.rd_data = V_EQUIP;
                    P_LOCK1:   r_d.rd_data = V_XFEAT;
                    P_KEY:     r_d.rd_data = V_KEY;
                    P_SYSCTL:  r_d.rd_data = {{(BYTE_W-CTL_W){1'b0}}, r_q.sysctl};
                    P_CACHEST: r_d.rd_data = V_CACHEST;
                    P_MAPTYPE: r_d.rd_data = {{(BYTE_W-1){1'b0}}, r_q.sparse};
                    default:   r_d.rd_data = V_UNUSED;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rd_valid      = r_q.rd_valid;
    assign rd_data       = r_q.rd_data;
    assign acc_err       = r_q.err;
    assign soft_reset    = r_q.soft_rst;
    assign little_endian = r_q.le;
    assign disk_light    = r_q.light;
    assign sys_ctl       = r_q.sysctl;
    assign map_sparse    = r_q.sparse;
    assign nv_lock_a     = r_q.lock_a;
    assign nv_lock_b     = r_q.lock_b;

    AST_SOFTRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(io_valid && io_write && io_addr == A_SPECIAL) |=> $stable(soft_reset)); // R1
    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(io_valid && io_write && io_addr == A_MAPTYPE) |=> $stable(map_sparse)); // R4
    AST_LOCKA_CAUSE: assert property (@(posedge clk) disable iff (rst)
        nv_lock_a |-> $past(io_valid && io_write && io_addr == A_LOCK1)); // R5
    AST_LOCKB_CAUSE: assert property (@(posedge clk) disable iff (rst)
        nv_lock_b |-> $past(io_valid && io_write && io_addr == A_LOCK2)); // R5
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> $past(io_valid)); // R7
    AST_FLAT_MAP: assert property (@(posedge clk) disable iff (rst)
        !map_sparse |-> io_port == cpu_offset[PORT_W-1:0]); // R8
    AST_RDVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(io_valid && !io_write)); // R10

endmodule

// File: tb/sysport_top_tb_top.sv
`timescale 1ns/1ps
module sysport_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [22:0] cpu_offset = '0;
    logic        rd_valid, acc_err, soft_reset, little_endian, disk_light;
    logic        map_sparse, nv_lock_a, nv_lock_b;
    logic [7:0]  rd_data;
    logic [3:0]  sys_ctl;
    logic [15:0] io_port;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sysport_top dut_i (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_wdata(io_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .acc_err(acc_err), .soft_reset(soft_reset),
        .little_endian(little_endian), .disk_light(disk_light),
        .sys_ctl(sys_ctl), .map_sparse(map_sparse), .nv_lock_a(nv_lock_a),
        .nv_lock_b(nv_lock_b), .cpu_offset(cpu_offset), .io_port(io_port)
    );

    // {write, addr, wdata, exp_rd, exp_err}
    localparam int NV = 14;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 16'h0800, 8'h00, 8'hEF, 1'b0},
        {1'b0, 16'h0802, 8'h00, 8'hAD, 1'b0},
        {1'b0, 16'h0803, 8'h00, 8'hE0, 1'b0},
        {1'b0, 16'h080C, 8'h00, 8'h3C, 1'b0},
        {1'b0, 16'h0810, 8'h00, 8'h39, 1'b0},
        {1'b0, 16'h0818, 8'h00, 8'h00, 1'b0},
        {1'b0, 16'h0823, 8'h00, 8'h03, 1'b0},
        {1'b0, 16'h0814, 8'h00, 8'hFF, 1'b0},
        {1'b0, 16'h0801, 8'h00, 8'hFF, 1'b1},
        {1'b0, 16'h0851, 8'h00, 8'hFF, 1'b1},
        {1'b0, 16'h0808, 8'h00, 8'hFF, 1'b1},
        {1'b0, 16'h0812, 8'h00, 8'hFF, 1'b1},
        {1'b1, 16'h0818, 8'h5A, 8'h00, 1'b1},
        {1'b1, 16'h0823, 8'hA5, 8'h00, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // request at negedge, registered result sampled 1 ns after the next posedge
    task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_valid = 1'b1; io_write = wr; io_addr = a; io_wdata = d;
        @(posedge clk);
        #1;
        io_valid = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] sparse_of(input logic [22:0] o);
        logic [31:0] w;
        w = ({9'b0, o} & 32'h1F) | (({9'b0, o} & 32'h7FF000) >> 7);
        return w[15:0];
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 state", {23'b0, soft_reset, little_endian, disk_light, sys_ctl, map_sparse,
             nv_lock_a, nv_lock_b}, 32'h0);

        // table walk: R6 fixed bytes, R7 unassigned
        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            access(v[33], v[32:17], v[16:9]);
            if (!v[33]) chk(v[0] ? "R7 rdata" : "R6 rdata", {24'b0, rd_data}, {24'b0, v[8:1]});
            chk(v[0] ? "R7 err" : "R6 err", {31'b0, acc_err}, {31'b0, v[0]});
        end
        chk("R7 no state change", {26'b0, soft_reset, little_endian, disk_light, sys_ctl[2:0]}, 32'h0);

        // R1
        access(1'b1, 16'h0092, 8'h03);
        chk("R1 softrst set", {31'b0, soft_reset}, 32'h1);
        chk("R1 le set", {31'b0, little_endian}, 32'h1);
        idle();
        chk("R1 softrst held", {31'b0, soft_reset}, 32'h1);
        access(1'b1, 16'h0092, 8'h02);
        chk("R1 softrst clr", {31'b0, soft_reset}, 32'h0);
        chk("R1 le kept", {31'b0, little_endian}, 32'h1);
        access(1'b0, 16'h0092, 8'h00);
        chk("R1 read", {23'b0, rd_valid, rd_data}, 32'h100);

        // R2
        access(1'b1, 16'h0808, 8'hFE);
        chk("R2 light bit0=0", {31'b0, disk_light}, 32'h0);
        access(1'b1, 16'h0808, 8'h01);
        chk("R2 light on", {31'b0, disk_light}, 32'h1);

        // R3
        access(1'b1, 16'h081C, 8'hA7);
        chk("R3 sysctl", {28'b0, sys_ctl}, 32'h7);
        access(1'b0, 16'h081C, 8'h00);
        chk("R3 read", {24'b0, rd_data}, 32'h07);

        // R6 writes to read-only ports: no effect
        access(1'b1, 16'h0800, 8'h00);
        chk("R6 wr no err", {31'b0, acc_err}, 32'h0);
        access(1'b1, 16'h0814, 8'hFF);
        chk("R6 wr 0814 no err", {31'b0, acc_err}, 32'h0);
        chk("R6 state kept", {24'b0, soft_reset, little_endian, disk_light, sys_ctl, map_sparse},
            {24'b0, 1'b0, 1'b1, 1'b1, 4'h7, 1'b0});

        // R5 strobes
        access(1'b1, 16'h0810, 8'h00);
        chk("R5 lock_a", {30'b0, nv_lock_a, nv_lock_b}, 32'h2);
        idle();
        chk("R5 lock_a drop", {30'b0, nv_lock_a, nv_lock_b}, 32'h0);
        access(1'b1, 16'h0812, 8'hC3);
        chk("R5 lock_b", {30'b0, nv_lock_a, nv_lock_b}, 32'h1);
        idle();
        chk("R5 lock_b drop", {30'b0, nv_lock_a, nv_lock_b}, 32'h0);

        // R4 / R8 / R9
        cpu_offset = 23'h7ABCDE;
        access(1'b0, 16'h0850, 8'h00);
        chk("R4 read 0", {24'b0, rd_data}, 32'h00);
        chk("R8 flat", {16'b0, io_port}, {16'b0, cpu_offset[15:0]});
        access(1'b1, 16'h0850, 8'hFF);
        chk("R4 set", {31'b0, map_sparse}, 32'h1);
        chk("R9 sparse", {16'b0, io_port}, {16'b0, sparse_of(cpu_offset)});
        cpu_offset = 23'h012FE1;
        #1;
        chk("R9 sparse 2", {16'b0, io_port}, {16'b0, sparse_of(cpu_offset)});
        access(1'b0, 16'h0850, 8'h00);
        chk("R4 read 1", {24'b0, rd_data}, 32'h01);

        // R10 outside window, and read latency
        access(1'b0, 16'h0900, 8'h00);
        chk("R10 outside", {30'b0, rd_valid, acc_err}, 32'h0);
        access(1'b0, 16'h0091, 8'h00);
        chk("R10 outside 2", {30'b0, rd_valid, acc_err}, 32'h0);
        access(1'b0, 16'h0802, 8'h00);
        chk("R10 valid", {31'b0, rd_valid}, 32'h1);
        idle();
        chk("R10 valid drop", {31'b0, rd_valid}, 32'h0);

        // R11 mid-run reset
        access(1'b1, 16'h0092, 8'h01);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R11 cleared", {24'b0, soft_reset, little_endian, disk_light, sys_ctl, map_sparse},
            32'h0);
        chk("R8 after reset", {16'b0, io_port}, {16'b0, cpu_offset[15:0]});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule